// File: doc/BRIEF.md
# Multiplexed Bus Cycle Generator

This block runs one machine cycle at a time on an 8-bit bus that carries the low address byte and the data on the same lines, with the high address byte on its own lines. A requester offers a cycle on a valid/ready request port. The request holds a kind code, a 16-bit address, a write byte and a flag that asks for a longer opcode fetch. The block then steps through T-states and produces the strobe and status pins for that cycle. A pulse marks the last T-state, and read data is returned with it.

The low address byte appears on the shared lines only in T1, while the address strobe is high. An address latch inside the block captures that byte on the strobe, so the full address is available from T2 on. From T2 the shared lines carry data. They are driven by the block on writes and by the bus target on reads.

Back-pressure follows the usual rules. The block raises `req_ready` when it is idle and during the final T-state of a cycle. A request moves only on a clock edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the requester must hold the request stable. The response side has no back-pressure: `rsp_valid` is high for exactly one clock.

Top module: `bus_cycle_gen`

## Requirements
- R1: `req_ready` is high in reset, when idle, and in the final T-state of a cycle, and low in every other T-state. A request accepted at a clock edge makes the next clock period T1. With `req_valid` low, no cycle starts.
- R2: `ale` is high for exactly one clock, which is T1. In T1, `ad_oe` is 1 and `ad_out` equals address bits 7..0.
- R3: `a_hi` carries address bits 15..8 in T1, T2 and T3, and is 0 in every other state.
- R4: From T2 through T3, `lat_addr` equals the full 16-bit request address. It is formed from `a_hi` and the byte latched while `ale` was high.
- R5: For the whole cycle, the status `{io_m,s1,s0}` is set by the kind. Opcode fetch (kind 0) is 011, memory read (kind 1) is 010 and memory write (kind 2) is 001. I/O read (kind 3) is 110 and I/O write (kind 4) is 101. When idle, the status is 000.
- R6: For read kinds (0, 1, 3), `rd_n` is low in T2 and T3 only and `wr_n` stays high. The `ad_in` value at the end of T3 is the data returned.
- R7: For write kinds (2, 4), `wr_n` is low in T2 and T3 only and `rd_n` stays high. In T2 and T3, `ad_oe` is 1 and `ad_out` equals the write byte.
- R8: An opcode fetch lasts 4 T-states, or 6 T-states when `req_long` is 1. Every other kind lasts 3 T-states, whatever the value of `req_long`.
- R9: `rsp_valid` is high for one clock, in the final T-state. In that same clock, `rsp_rdata` holds the read data of a read kind.
- R10: Kind codes 5, 6 and 7 run as a memory read, with status 010, 3 T-states and a read strobe.
- R11: In T4 to T6 of a fetch, `rd_n`, `wr_n` and `ale` are inactive and `ad_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block accepts a request at this edge |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write byte |
| req_long | input | 1 | Ask for the six-state opcode fetch |
| rsp_valid | output | 1 | Final T-state pulse |
| rsp_rdata | output | 8 | Data read during the cycle |
| ale | output | 1 | Address strobe, high in T1 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| a_hi | output | 8 | High address byte |
| ad_out | output | 8 | Value the block drives on the shared lines |
| ad_oe | output | 1 | The block drives the shared lines |
| ad_in | input | 8 | Value the target drives on the shared lines |
| lat_addr | output | 16 | Full address from the address latch |

## Verification
The bench aims at the lengths of the different cycles. A design that ignores `req_long` would signal done in T4 of a long fetch. A design that applies it to reads would stretch a memory read to six states. Both show up when done is compared with the counted T-state. Requests sent back to back check that done and the next T1 have no idle clock between them, and that the earlier read data is not lost in the turnover. Undefined kind codes are sent too. A design that decodes them as writes would drive `wr_n` and the write byte in the wrong cycle.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  typedef enum logic [2:0] {
    CK_FETCH = 3'd0,
    CK_MRD   = 3'd1,
    CK_MWR   = 3'd2,
    CK_IORD  = 3'd3,
    CK_IOWR  = 3'd4
  } cyc_kind_e;

  typedef struct packed {
    logic io_m;
    logic s1;
    logic s0;
  } bus_status_t;

  localparam bus_status_t ST_IDLE = '{io_m: 1'b0, s1: 1'b0, s0: 1'b0};

  function automatic bus_status_t status_for(input logic [2:0] kind);
    bus_status_t st;
    case (kind)
      CK_FETCH: st = '{io_m: 1'b0, s1: 1'b1, s0: 1'b1};
      CK_MWR:   st = '{io_m: 1'b0, s1: 1'b0, s0: 1'b1};
      CK_IORD:  st = '{io_m: 1'b1, s1: 1'b1, s0: 1'b0};
      CK_IOWR:  st = '{io_m: 1'b1, s1: 1'b0, s0: 1'b1};
      default:  st = '{io_m: 1'b0, s1: 1'b1, s0: 1'b0};
    endcase
    return st;
  endfunction

  function automatic logic kind_writes(input logic [2:0] kind);
    return (kind == CK_MWR) || (kind == CK_IOWR);
  endfunction

  function automatic logic kind_fetch(input logic [2:0] kind);
    return kind == CK_FETCH;
  endfunction

endpackage

// File: rtl/bcg_tstate_seq.sv
module bcg_tstate_seq
  import bcg_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int FETCH_LEN = 4,
  parameter int LONG_LEN  = 6,
  parameter int RW_LEN    = 3,
  localparam int TW       = $clog2(LONG_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_long,
  input  logic [DATA_W-1:0] ad_in,
  output logic              busy,
  output logic [TW-1:0]     tstate,
  output logic [2:0]        kind_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam logic [TW-1:0] T_FIRST   = TW'(1);
  localparam logic [TW-1:0] T_SAMPLE  = TW'(RW_LEN);
  localparam logic [TW-1:0] T_SHORT   = TW'(FETCH_LEN);
  localparam logic [TW-1:0] T_LONG    = TW'(LONG_LEN);
  localparam logic [TW-1:0] T_RW      = TW'(RW_LEN);

  logic              long_q;
  logic [DATA_W-1:0] rdata_q;
  logic [TW-1:0]     last_t;
  logic              last;
  logic              accept;
  logic              reads;

  always_comb begin
    if (kind_fetch(kind_q)) last_t = long_q ? T_LONG : T_SHORT;
    else                    last_t = T_RW;
  end

  assign last      = busy && (tstate == last_t);
  assign req_ready = !busy || last;
  assign accept    = req_valid && req_ready;
  assign reads     = !kind_writes(kind_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      tstate  <= '0;
      kind_q  <= 3'd0;
      addr_q  <= '0;
      wdata_q <= '0;
      long_q  <= 1'b0;
    end else if (accept) begin
      busy    <= 1'b1;
      tstate  <= T_FIRST;
      kind_q  <= req_kind;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      long_q  <= req_long;
    end else if (last) begin
      busy    <= 1'b0;
      tstate  <= '0;
    end else if (busy) begin
      tstate  <= tstate + TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                       rdata_q <= '0;
    else if (busy && reads && tstate == T_SAMPLE)     rdata_q <= ad_in;
  end

  assign rsp_valid = last;
  assign rsp_rdata = (tstate == T_SAMPLE) ? ad_in : rdata_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9
  AST_READY_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tstate == T_FIRST) |-> !req_ready); // R1

endmodule

// File: rtl/bcg_pin_drive.sv
module bcg_pin_drive
  import bcg_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int RW_LEN    = 3,
  parameter int LONG_LEN  = 6,
  localparam int HI_W     = ADDR_W - DATA_W,
  localparam int TW       = $clog2(LONG_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic [TW-1:0]     tstate,
  input  logic [2:0]        kind_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic              s1,
  output logic              s0,
  output logic [HI_W-1:0]   a_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe
);

  localparam logic [TW-1:0] T_ONE  = TW'(1);
  localparam logic [TW-1:0] T_TWO  = TW'(2);
  localparam logic [TW-1:0] T_LAST = TW'(RW_LEN);

  bus_status_t st;
  logic in_t1, in_data, in_addr_win, wr_kind;

  assign in_t1       = busy && (tstate == T_ONE);
  assign in_data     = busy && (tstate >= T_TWO) && (tstate <= T_LAST);
  assign in_addr_win = busy && (tstate >= T_ONE) && (tstate <= T_LAST);
  assign wr_kind     = kind_writes(kind_q);

  always_comb begin
    st = busy ? status_for(kind_q) : ST_IDLE;
    io_m = st.io_m;
    s1   = st.s1;
    s0   = st.s0;
  end

  always_comb begin
    ale    = in_t1;
    rd_n   = !(in_data && !wr_kind);
    wr_n   = !(in_data && wr_kind);
    a_hi   = in_addr_win ? addr_q[ADDR_W-1:DATA_W] : '0;
    ad_oe  = in_t1 || (in_data && wr_kind);
    if (in_t1)                    ad_out = addr_q[DATA_W-1:0];
    else if (in_data && wr_kind)  ad_out = wdata_q;
    else                          ad_out = '0;
  end

  AST_ALE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R2
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R6
  AST_RD_TWO_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |=> (!rd_n ##1 rd_n)); // R6
  AST_WR_TWO_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |=> (!wr_n ##1 wr_n)); // R7
  AST_WR_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe); // R7

endmodule

// File: rtl/bcg_addr_latch.sv
module bcg_addr_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic [DATA_W-1:0] ad_lo,
  output logic [DATA_W-1:0] lat_lo
);

  always_ff @(posedge clk) begin
    if (!rst_n)   lat_lo <= '0;
    else if (ale) lat_lo <= ad_lo;
  end

  AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (lat_lo == $past(ad_lo))); // R4

endmodule

// File: rtl/bus_cycle_gen.sv
module bus_cycle_gen
  import bcg_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int FETCH_LEN = 4,
  parameter int LONG_LEN  = 6,
  parameter int RW_LEN    = 3,
  localparam int HI_W     = ADDR_W - DATA_W,
  localparam int TW       = $clog2(LONG_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_long,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic              s1,
  output logic              s0,
  output logic [HI_W-1:0]   a_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic [ADDR_W-1:0] lat_addr
);

  logic              busy;
  logic [TW-1:0]     tstate;
  logic [2:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] lat_lo;

  bcg_tstate_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FETCH_LEN(FETCH_LEN),
    .LONG_LEN(LONG_LEN), .RW_LEN(RW_LEN)
  ) seq_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_long(req_long),
    .ad_in(ad_in), .busy(busy), .tstate(tstate), .kind_q(kind_q),
    .addr_q(addr_q), .wdata_q(wdata_q),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  bcg_pin_drive #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RW_LEN(RW_LEN), .LONG_LEN(LONG_LEN)
  ) drv_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .tstate(tstate),
    .kind_q(kind_q), .addr_q(addr_q), .wdata_q(wdata_q),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .s1(s1), .s0(s0),
    .a_hi(a_hi), .ad_out(ad_out), .ad_oe(ad_oe)
  );

  bcg_addr_latch #(.DATA_W(DATA_W)) lat_i (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_lo(ad_out), .lat_lo(lat_lo)
  );

  assign lat_addr = {a_hi, lat_lo};

  AST_ACCEPT_STARTS_T1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ale); // R1
  AST_NO_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !busy) |=> !ale); // R1
  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ale && !$past(rsp_valid)) |-> $stable({io_m, s1, s0})); // R5

endmodule

// File: tb/bus_cycle_gen_tb_top.sv
`timescale 1ns/1ps
module bus_cycle_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = 3'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic        req_long = 1'b0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        ale, rd_n, wr_n, io_m, s1, s0, ad_oe;
  logic [7:0]  a_hi, ad_out, ad_in;
  logic [15:0] lat_addr;

  always #4 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign ad_in = !rd_n ? memf(lat_addr) : 8'hEE;

  bus_cycle_gen dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_long(req_long), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .s1(s1), .s0(s0),
    .a_hi(a_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .lat_addr(lat_addr)
  );

  typedef struct {
    logic [2:0]  kind;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic        lng;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] exp_status(input logic [2:0] k);
    case (k)
      3'd0: return 3'b011;
      3'd2: return 3'b001;
      3'd3: return 3'b110;
      3'd4: return 3'b101;
      default: return 3'b010;
    endcase
  endfunction

  function automatic bit is_wr(input logic [2:0] k);
    return (k == 3'd2) || (k == 3'd4);
  endfunction

  function automatic int exp_len(input item_t it);
    if (it.kind == 3'd0) return it.lng ? 6 : 4;
    return 3;
  endfunction

  // monitor: pops expected items on each T1 and checks every T-state
  int    t = 0;
  item_t cur;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ale) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected cycle", 32'd1, 32'd0);
          cur = '{kind: 3'd1, addr: 16'h0, wdata: 8'h0, lng: 1'b0};
        end else cur = exp_q.pop_front();
        t = 1;
      end else if (t > 0) t++;

      if (t == 1) begin
        check(ad_oe && ad_out == cur.addr[7:0], "R2 low address in T1", ad_out, cur.addr[7:0]);
        check(a_hi == cur.addr[15:8], "R3 high byte T1", a_hi, cur.addr[15:8]);
        check(rd_n && wr_n, "R6 strobes idle in T1", {rd_n, wr_n}, 2'b11);
      end else if (t == 2 || t == 3) begin
        check(!ale, "R2 ale low after T1", ale, 0);
        check(a_hi == cur.addr[15:8], "R3 high byte T2/T3", a_hi, cur.addr[15:8]);
        check(lat_addr == cur.addr, "R4 latched address", lat_addr, cur.addr);
        if (is_wr(cur.kind)) begin
          check(!wr_n && rd_n, "R7 write strobe", {rd_n, wr_n}, 2'b10);
          check(ad_oe && ad_out == cur.wdata, "R7 write data", ad_out, cur.wdata);
        end else begin
          check(!rd_n && wr_n, "R6/R10 read strobe", {rd_n, wr_n}, 2'b01);
          check(!ad_oe, "R6 bus released", ad_oe, 0);
        end
        if (t == 2) check(!req_ready, "R1 busy not ready", req_ready, 0);
      end else if (t >= 4) begin
        check(rd_n && wr_n && !ale && !ad_oe, "R11 internal states quiet",
              {rd_n, wr_n, ale, ad_oe}, 4'b1100);
        check(a_hi == 8'h0, "R3 high byte cleared", a_hi, 0);
      end

      if (t > 0)
        check({io_m, s1, s0} == exp_status(cur.kind), "R5 status",
              {io_m, s1, s0}, exp_status(cur.kind));

      if (rsp_valid) begin
        check(t == exp_len(cur), "R8 cycle length", t, exp_len(cur));
        check(req_ready, "R1 ready in final state", req_ready, 1);
        if (!is_wr(cur.kind))
          check(rsp_rdata == memf(cur.addr), "R9 read data", rsp_rdata, memf(cur.addr));
        t = 0;
      end else if (t == 0) begin
        check(!ale && rd_n && wr_n && {io_m, s1, s0} == 3'b000, "R5 idle pins",
              {ale, rd_n, wr_n, io_m, s1, s0}, 6'b011000);
      end else if (t > exp_len(cur)) begin
        check(1'b0, "R9 missing done", t, exp_len(cur));
        t = 0;
      end
    end
  end

  task automatic send(input logic [2:0] k, input logic [15:0] a,
                      input logic [7:0] d, input logic lng);
    item_t it;
    it = '{kind: k, addr: a, wdata: d, lng: lng};
    exp_q.push_back(it);
    req_kind = k; req_addr = a; req_wdata = d; req_long = lng;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  bit timed_out = 0;

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check(req_ready && rd_n && wr_n && !ale, "R1 reset state",
              {req_ready, rd_n, wr_n, ale}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        repeat (4) @(negedge clk);          // R1: no request, no cycle
        send(3'd0, 16'h2003, 8'h00, 1'b0);  // short fetch
        repeat (8) @(negedge clk);
        send(3'd0, 16'h1FFF, 8'h00, 1'b1);  // long fetch R8
        repeat (8) @(negedge clk);
        send(3'd1, 16'h4050, 8'h00, 1'b0);
        repeat (5) @(negedge clk);
        send(3'd2, 16'h20F0, 8'h5A, 1'b0);
        repeat (5) @(negedge clk);
        send(3'd3, 16'h00F0, 8'h00, 1'b0);
        repeat (5) @(negedge clk);
        send(3'd4, 16'h0081, 8'hC3, 1'b0);
        repeat (5) @(negedge clk);
        send(3'd1, 16'hABCD, 8'h00, 1'b1);  // R8 flag ignored
        repeat (5) @(negedge clk);
        send(3'd6, 16'h1234, 8'h99, 1'b0);  // R10 undefined kind
        repeat (5) @(negedge clk);
        // back to back
        send(3'd1, 16'h0102, 8'h00, 1'b0);
        send(3'd0, 16'hFF00, 8'h00, 1'b1);
        send(3'd4, 16'h7777, 8'hA5, 1'b0);
        send(3'd3, 16'h8001, 8'h00, 1'b0);
        send(3'd0, 16'h0000, 8'h00, 1'b0);
        repeat (12) @(negedge clk);
        check(exp_q.size() == 0 && t == 0, "R9 all cycles completed", exp_q.size(), 0);
      end
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1 actual=hung expected=done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule